// File: doc/BRIEF.md
# Parallel Printer Strobe Sequencer

This block feeds a parallel printer port one byte at a time. A producer offers a byte over a valid/ready handshake. The block stores the byte in an output latch that drives the printer data lines. It then waits until the printer shows neither a busy condition nor an out-of-paper condition. After that it drives an active-low strobe for a fixed number of clock cycles, and only then does it take the next byte.

The two printer status lines pass through a synchronizer before the sequencer uses them. Their synchronized values also appear in a status word: busy at bit 5 and paper-empty at bit 6. A separate control write sets a software strobe bit. When that bit is written to 0, the strobe is forced low, whatever the sequencer is doing. The data latch is loaded only by the handshake, never by the control write.

The strobe width is given as a number of clocks. The default of 160 clocks at a 16 MHz clock gives a pulse of at least 10 µs.

Top module: `prt_strobe_seq`

## Requirements
- R1: After reset, `in_ready_o` is 1, `strobe_n_o` is 1, `prn_data_o` is 0, `status_o` is 0 and the software strobe bit is 1.
- R2: On a clock edge where `in_valid_i` and `in_ready_o` are both 1, the byte is accepted. From the next cycle, `prn_data_o` holds that byte and `in_ready_o` is 0.
- R3: While either synchronized status bit is 1, the strobe does not fall. Once both status inputs have been low for long enough, the strobe falls four clock edges after the inputs cleared. If both were already clear at acceptance, it falls two edges after the acceptance edge.
- R4: A sequencer strobe pulse stays low for exactly STROBE_CYC clock cycles (default 160).
- R5: `prn_data_o` stays unchanged from acceptance until after the pulse has ended. It is therefore stable for at least one clock before the strobe falls and for at least one clock after it rises.
- R6: `in_ready_o` stays 0 from acceptance through the pulse. It returns to 1 one clock edge after the strobe rises (HOLD_CYC = 1).
- R7: `status_o` carries the busy input at bit 5 and the paper-empty input at bit 6, each delayed by two clock edges. All other bits of `status_o` are 0.
- R8: A control write (`ctl_wr_i`) with `ctl_d_i` = 0 drives `strobe_n_o` low from the next cycle on. A control write with `ctl_d_i` = 1 releases it. Neither write changes `prn_data_o` or `in_ready_o`.
- R9: A valid byte offered while `in_ready_o` is 0 is ignored. It does not change `prn_data_o` and does not cause a second strobe pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Byte offered |
| in_data_i | input | DATA_W | Byte to print |
| in_ready_o | output | 1 | Block can accept a byte |
| busy_i | input | 1 | Printer busy, asynchronous |
| pe_i | input | 1 | Printer out of paper, asynchronous |
| ctl_wr_i | input | 1 | Write strobe for the software strobe bit |
| ctl_d_i | input | 1 | Value of the software strobe bit (0 forces strobe low) |
| prn_data_o | output | DATA_W | Printer data lines |
| strobe_n_o | output | 1 | Active-low printer strobe |
| status_o | output | STAT_W | Status word: busy at bit 5, paper-empty at bit 6 |

## Verification
Two functions can act on the strobe line in the same cycle: the sequencer pulse and the software override. The bench forces the strobe low through the control bit while the block is idle. It also forces it low while a byte is parked waiting on a busy printer. It then judges that the handshake and data lines are undisturbed, and that the pulse that follows still has its full width. Acceptance of a byte and a change on the status inputs can also land together. The bench raises busy or paper-empty in the same setup window as the handshake and checks that the fall is held off until both lines have cleared and passed the synchronizer.

// File: rtl/prt_pkg.sv
package prt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD
  } seq_st_t;
endpackage

// File: rtl/prt_sync.sv
module prt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/prt_dncnt.sv
module prt_dncnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         en,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (ld) cnt <= ld_val;
    else if (en) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/prt_strobe_seq.sv
module prt_strobe_seq
  import prt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STROBE_CYC  = 160,
  parameter int SETUP_CYC   = 1,
  parameter int HOLD_CYC    = 1,
  parameter int SYNC_STAGES = 2,
  parameter int STAT_W      = 8,
  parameter int BUSY_BIT    = 5,
  parameter int PE_BIT      = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  input  logic              busy_i,
  input  logic              pe_i,
  input  logic              ctl_wr_i,
  input  logic              ctl_d_i,
  output logic [DATA_W-1:0] prn_data_o,
  output logic              strobe_n_o,
  output logic [STAT_W-1:0] status_o
);
  localparam int MAXC0 = (STROBE_CYC > SETUP_CYC) ? STROBE_CYC : SETUP_CYC;
  localparam int MAXC  = (MAXC0 > HOLD_CYC) ? MAXC0 : HOLD_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  // status synchronizer: bit 1 = busy, bit 0 = paper empty
  logic [1:0] st_raw, st_syn;
  assign st_raw = {busy_i, pe_i};

  prt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(st_raw), .q(st_syn)
  );

  logic busy_s, pe_s;
  assign busy_s = st_syn[1];
  assign pe_s   = st_syn[0];

  always_comb begin
    status_o           = '0;
    status_o[BUSY_BIT] = busy_s;
    status_o[PE_BIT]   = pe_s;
  end

  // sequencer state
  seq_st_t           st_q, st_nx;
  logic              rdy_q, stb_q, ctl_q;
  logic [DATA_W-1:0] data_q;
  logic              cnt_ld, cnt_en, cnt_zero;
  logic [CNT_W-1:0]  cnt_ldv;
  logic              acc;

  assign acc = in_valid_i && rdy_q;

  prt_dncnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .ld(cnt_ld), .ld_val(cnt_ldv),
    .en(cnt_en), .zero(cnt_zero)
  );

  always_comb begin
    st_nx   = st_q;
    cnt_ld  = 1'b0;
    cnt_en  = 1'b0;
    cnt_ldv = '0;
    case (st_q)
      ST_IDLE:  if (acc) st_nx = ST_WAIT;
      ST_WAIT: begin
        if (!busy_s && !pe_s) begin
          st_nx   = ST_SETUP;
          cnt_ld  = 1'b1;
          cnt_ldv = CNT_W'(SETUP_CYC - 1);
        end
      end
      ST_SETUP: begin
        if (cnt_zero) begin
          st_nx   = ST_PULSE;
          cnt_ld  = 1'b1;
          cnt_ldv = CNT_W'(STROBE_CYC - 1);
        end else cnt_en = 1'b1;
      end
      ST_PULSE: begin
        if (cnt_zero) begin
          st_nx   = ST_HOLD;
          cnt_ld  = 1'b1;
          cnt_ldv = CNT_W'(HOLD_CYC - 1);
        end else cnt_en = 1'b1;
      end
      ST_HOLD: begin
        if (cnt_zero) st_nx = ST_IDLE;
        else          cnt_en = 1'b1;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      rdy_q  <= 1'b1;
      stb_q  <= 1'b1;
      ctl_q  <= 1'b1;
      data_q <= '0;
    end else begin
      st_q  <= st_nx;
      rdy_q <= (st_nx == ST_IDLE);
      stb_q <= (st_nx != ST_PULSE);
      if (acc)      data_q <= in_data_i;
      if (ctl_wr_i) ctl_q  <= ctl_d_i;
    end
  end

  assign in_ready_o = rdy_q;
  assign prn_data_o = data_q;
  assign strobe_n_o = stb_q & ctl_q;

  // ---------------- assertions ----------------
  logic [CNT_W:0] lo_cnt;
  always_ff @(posedge clk) begin
    if (rst)         lo_cnt <= '0;
    else if (!stb_q) lo_cnt <= lo_cnt + 1'b1;
    else             lo_cnt <= '0;
  end

  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && in_ready_o) |=> (!in_ready_o && prn_data_o == $past(in_data_i)));

  a_r3_gate: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && (busy_s || pe_s)) |=> (st_q == ST_WAIT && stb_q));

  a_r4_width: assert property (@(posedge clk) disable iff (rst)
    $rose(stb_q) |-> (lo_cnt == (CNT_W+1)'(STROBE_CYC)));

  a_r5_data_stable: assert property (@(posedge clk) disable iff (rst)
    !in_ready_o |=> $stable(prn_data_o));

  a_r6_no_ready_in_pulse: assert property (@(posedge clk) disable iff (rst)
    !stb_q |-> !in_ready_o);

  a_r8_override_low: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr_i && !ctl_d_i) |=> !strobe_n_o);
endmodule

// File: tb/tb_prt_strobe_seq.sv
module tb_prt_strobe_seq;
  localparam int STB = 160;

  logic       clk = 1'b0;
  logic       rst;
  logic       vld, busy, pe, cwr, cd;
  logic [7:0] din, pdata, stat;
  logic       rdy, stbn;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  prt_strobe_seq #(.STROBE_CYC(STB)) dut (
    .clk(clk), .rst(rst), .in_valid_i(vld), .in_data_i(din), .in_ready_o(rdy),
    .busy_i(busy), .pe_i(pe), .ctl_wr_i(cwr), .ctl_d_i(cd),
    .prn_data_o(pdata), .strobe_n_o(stbn), .status_o(stat)
  );

  // {data[17:10], busy[9], pe[8], wait cycles[7:0]}
  localparam logic [17:0] VEC [6] = '{
    {8'hA5, 1'b0, 1'b0, 8'd0},
    {8'h3C, 1'b1, 1'b0, 8'd5},
    {8'hFF, 1'b0, 1'b1, 8'd7},
    {8'h00, 1'b1, 1'b1, 8'd3},
    {8'h81, 1'b0, 1'b0, 8'd0},
    {8'h7E, 1'b1, 1'b0, 8'd1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit b, input bit p, input int nw);
    int n, m;
    bit rdy_bad, dat_bad;
    busy = b; pe = p;
    repeat (3) tick;
    vld = 1'b1; din = d;
    tick;
    vld = 1'b0;
    chk(pdata == d, "R2 byte on data lines", pdata, d);
    chk(rdy == 1'b0, "R2 ready drops on accept", rdy, 0);
    if (b || p) begin
      for (int i = 0; i < nw; i++) begin
        tick;
        chk(stbn == 1'b1, "R3 strobe held while blocked", stbn, 1);
      end
      busy = 1'b0; pe = 1'b0;
    end
    n = 0;
    do begin tick; n++; end while (stbn && n < 20);
    chk(n == ((b || p) ? 4 : 2), "R3 strobe start latency", n, (b || p) ? 4 : 2);
    chk(pdata == d, "R5 data valid at strobe fall", pdata, d);
    m = 0; rdy_bad = 0; dat_bad = 0;
    while (!stbn && m < 1000) begin
      if (rdy) rdy_bad = 1;
      if (pdata != d) dat_bad = 1;
      tick; m++;
    end
    chk(m == STB, "R4 strobe low width", m, STB);
    chk(!rdy_bad, "R6 ready low during pulse", rdy_bad, 0);
    chk(!dat_bad, "R5 data stable during pulse", dat_bad, 0);
    chk(pdata == d, "R5 data held after rise", pdata, d);
    chk(rdy == 1'b0, "R6 ready still low at rise", rdy, 0);
    tick;
    chk(rdy == 1'b1, "R6 ready back one edge after rise", rdy, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; vld = 0; din = 0; busy = 0; pe = 0; cwr = 0; cd = 0;
    repeat (3) tick;
    rst = 1'b0;
    chk(rdy == 1'b1, "R1 reset ready", rdy, 1);
    chk(stbn == 1'b1, "R1 reset strobe", stbn, 1);
    chk(pdata == 8'h00, "R1 reset data", pdata, 0);
    chk(stat == 8'h00, "R1 reset status", stat, 0);

    foreach (VEC[i]) send(VEC[i][17:10], VEC[i][9], VEC[i][8], int'(VEC[i][7:0]));

    // R7: status word with two-edge synchronizer
    busy = 1'b1; tick;
    chk(stat[5] == 1'b0, "R7 busy not yet through sync", stat[5], 0);
    tick;
    chk(stat == 8'h20, "R7 busy at bit 5", stat, 8'h20);
    busy = 1'b0; pe = 1'b1; tick;
    chk(stat == 8'h20, "R7 one edge lag", stat, 8'h20);
    tick;
    chk(stat == 8'h40, "R7 paper empty at bit 6", stat, 8'h40);
    pe = 1'b0; repeat (2) tick;
    chk(stat == 8'h00, "R7 status clears", stat, 0);

    // R8: software override while idle
    cwr = 1'b1; cd = 1'b0; tick; cwr = 1'b0;
    chk(stbn == 1'b0, "R8 override drives strobe low", stbn, 0);
    chk(rdy == 1'b1, "R8 override leaves ready", rdy, 1);
    repeat (5) tick;
    chk(stbn == 1'b0, "R8 override persists", stbn, 0);
    chk(pdata == 8'h7E, "R8 override leaves data", pdata, 8'h7E);
    cwr = 1'b1; cd = 1'b1; tick; cwr = 1'b0;
    chk(stbn == 1'b1, "R8 override release", stbn, 1);

    // R8 + R3: override while a byte waits on a busy printer
    busy = 1'b1; repeat (3) tick;
    vld = 1'b1; din = 8'h5A; tick; vld = 1'b0;
    cwr = 1'b1; cd = 1'b0; tick; cwr = 1'b0;
    chk(stbn == 1'b0, "R8 override low while waiting", stbn, 0);
    chk(rdy == 1'b0 && pdata == 8'h5A, "R8 waiting byte undisturbed", pdata, 8'h5A);
    cwr = 1'b1; cd = 1'b1; tick; cwr = 1'b0;
    chk(stbn == 1'b1, "R3 blocked strobe high after release", stbn, 1);
    send_rest(8'h5A);

    // R9: bytes offered while not ready are ignored
    busy = 1'b1; repeat (3) tick;
    vld = 1'b1; din = 8'h11; tick;
    din = 8'hEE; repeat (4) tick; vld = 1'b0;
    chk(pdata == 8'h11, "R9 offered byte ignored", pdata, 8'h11);
    send_rest(8'h11);
    begin
      bit extra;
      extra = 0;
      for (int i = 0; i < 10; i++) begin
        tick;
        if (!stbn || pdata != 8'h11) extra = 1;
      end
      chk(!extra, "R9 no second pulse", extra, 0);
    end

    // R1: reset in the middle of a pulse
    vld = 1'b1; din = 8'hC3; tick; vld = 1'b0;
    repeat (5) tick;
    chk(stbn == 1'b0, "R4 pulse under way before reset", stbn, 0);
    rst = 1'b1; tick; rst = 1'b0;
    chk(rdy == 1'b1 && stbn == 1'b1, "R1 mid-pulse reset ready/strobe", {rdy, stbn}, 3);
    chk(pdata == 8'h00, "R1 mid-pulse reset data", pdata, 0);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // clears busy on a parked byte and checks the pulse that follows
  task automatic send_rest(input logic [7:0] d);
    int n, m;
    busy = 1'b0; pe = 1'b0;
    n = 0;
    do begin tick; n++; end while (stbn && n < 20);
    chk(n == 4, "R3 fall after status clear", n, 4);
    m = 0;
    while (!stbn && m < 1000) begin tick; m++; end
    chk(m == STB, "R4 full width after override", m, STB);
    chk(pdata == d, "R5 data held after rise", pdata, d);
    tick;
    chk(rdy == 1'b1, "R6 ready returns", rdy, 1);
  endtask
endmodule